// File: doc/BRIEF.md
# Variable-Length Opcode Decoder

This block takes a stream of 16-bit instruction words and decodes each one. The opcode has no fixed length. Any top nibble except all ones is a complete opcode that leaves three 4-bit register fields. An all-ones nibble works as an escape and extends the opcode into the next nibble, at the cost of one operand field. Four operand classes share the word in this way: three, two, one and zero register operands. Between them they cover all 65536 encodings, so no word is illegal.

For every accepted word the decoder produces a registered record one cycle later. The record holds the operand class, a dense instruction index running from 0 to 75 across all classes, and the three register fields. Each field comes with a flag that says whether it is meaningful, and a field that is not meaningful is forced to zero. Input and output both use valid/ready handshakes, and the output register stalls while the consumer holds ready low.

Top module: `xop_decoder`

## Requirements
- R1: When bits [15:12] are 0x0 to 0xE, the class is three-operand (out_class = 2'b00), the index equals bits [15:12], and out_f2/out_f1/out_f0 carry bits [11:8]/[7:4]/[3:0].
- R2: When bits [15:12] are 0xF and bits [11:8] are 0x0 to 0xD, the class is two-operand (2'b01), the index is 15 + bits [11:8], and out_f1/out_f0 carry bits [7:4]/[3:0].
- R3: When bits [15:8] are 0xFE, the class is one-operand (2'b10) with index 29 + bits [7:4]. When bits [15:8] are 0xFF and bits [7:4] are 0x0 to 0xE, the class is also one-operand, with index 45 + bits [7:4]. In both cases out_f0 carries bits [3:0].
- R4: When bits [15:4] are 0xFFF, the class is zero-operand (2'b11) and the index is 60 + bits [3:0], so word 0xFFFF decodes to index 75.
- R5: Every one of the 65536 words decodes to a valid instruction. The three-, two-, one- and zero-operand classes receive 61440, 3584, 496 and 16 words respectively, and the indices 0 to 75 are each produced.
- R6: out_used bit k (where bit 2 is f2, bit 1 is f1 and bit 0 is f0) is set exactly when field k is an operand of the class: 3'b111, 3'b011, 3'b001 or 3'b000. A field whose flag is clear reads zero.
- R7: After reset out_valid is low. A word accepted on a rising edge (in_valid and in_ready both high) appears on the outputs after that edge, with out_valid high. An edge that delivers the record while no new word arrives clears out_valid.
- R8: While out_valid is high and out_ready is low, in_ready is low and the output record holds steady. When out_ready rises, a waiting word is accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | The decoder can accept a word this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | The decoded record is valid |
| out_ready | input | 1 | The consumer takes the record |
| out_class | output | 2 | Operand class: 00 three, 01 two, 10 one, 11 zero |
| out_index | output | 7 | Dense instruction index, 0 to 75 |
| out_f2 | output | 4 | Register field from bits [11:8], or zero |
| out_f1 | output | 4 | Register field from bits [7:4], or zero |
| out_f0 | output | 4 | Register field from bits [3:0], or zero |
| out_used | output | 3 | Per-field meaningful flags, bit k for field k |

## Verification
The hard cases sit at the escape boundaries: 0xEFFF against 0xF000, 0xFDFF against 0xFE00, 0xFEFF against 0xFF00, and 0xFFEF against 0xFFF0. A comparison that is off by one here moves a whole block of words into the wrong class, and the indices then fall into gaps or overlap. A full sweep of all 65536 words counts the words in each class and the distinct indices, so a shifted escape or a wrong base offset shows up as a miscount. The bench also checks that the fields of unused operands read zero, because a decoder that passes raw bits through would leak opcode nibbles. The stall test catches a record that changes while held, and an input that is accepted and then dropped during back-pressure.

// File: rtl/xop_pkg.sv
package xop_pkg;

    // Operand class of a decoded word; the numeric values are visible at the port
    typedef enum logic [1:0] {
        CLS_THREE = 2'b00,
        CLS_TWO   = 2'b01,
        CLS_ONE   = 2'b10,
        CLS_ZERO  = 2'b11
    } opclass_e;

    // Number of register operand fields below the leading nibble
    localparam int unsigned NOPS = 3;

endpackage

// File: rtl/xop_class_detect.sv
// Finds where the escape chain of all-ones nibbles ends and reports the class
module xop_class_detect
    import xop_pkg::*;
#(
    parameter int unsigned FIELD_W = 4
) (
    input  logic [(NOPS+1)*FIELD_W-1:0] word,
    output opclass_e                    cls,
    output logic                        one_upper
);
    localparam int unsigned NNIB = NOPS + 1;
    localparam logic [FIELD_W-1:0] ONES = {FIELD_W{1'b1}};
    localparam logic [FIELD_W-1:0] NEAR = ONES - FIELD_W'(1);

    logic [FIELD_W-1:0] nib [NNIB];
    logic [NNIB-1:0]    is_ones;
    logic [NNIB-1:0]    is_near;

    for (genvar k = 0; k < NNIB; k++) begin : g_nib
        assign nib[k]     = word[k*FIELD_W +: FIELD_W];
        assign is_ones[k] = (nib[k] == ONES);
        assign is_near[k] = (nib[k] == NEAR);
    end

    always_comb begin
        cls       = CLS_THREE;
        one_upper = 1'b0;
        if (!is_ones[3]) begin
            cls = CLS_THREE;
        end else if (!is_ones[2] && !is_near[2]) begin
            cls = CLS_TWO;
        end else if (is_near[2]) begin
            cls = CLS_ONE;
        end else if (!is_ones[1]) begin
            cls       = CLS_ONE;
            one_upper = 1'b1;
        end else begin
            cls = CLS_ZERO;
        end
    end

endmodule

// File: rtl/xop_field_extract.sv
// Builds the dense index, the used flags and the masked register fields
module xop_field_extract
    import xop_pkg::*;
#(
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned IDX_W   = 7
) (
    input  logic [(NOPS+1)*FIELD_W-1:0]  word,
    input  opclass_e                     cls,
    input  logic                         one_upper,
    output logic [IDX_W-1:0]             index,
    output logic [NOPS-1:0][FIELD_W-1:0] fld,
    output logic [NOPS-1:0]              used
);
    localparam int unsigned SPAN  = 1 << FIELD_W;
    localparam int unsigned N3    = SPAN - 1;
    localparam int unsigned N2    = SPAN - 2;
    localparam int unsigned N1    = 2 * SPAN - 1;
    localparam int unsigned BASE2 = N3;
    localparam int unsigned BASE1 = N3 + N2;
    localparam int unsigned BASE0 = N3 + N2 + N1;

    logic [1:0] nops;

    always_comb begin
        unique case (cls)
            CLS_THREE: nops = 2'd3;
            CLS_TWO:   nops = 2'd2;
            CLS_ONE:   nops = 2'd1;
            default:   nops = 2'd0;
        endcase
    end

    for (genvar k = 0; k < NOPS; k++) begin : g_fld
        assign used[k] = (int'(nops) > k);
        assign fld[k]  = used[k] ? word[k*FIELD_W +: FIELD_W] : '0;
    end

    always_comb begin
        unique case (cls)
            CLS_THREE: index = IDX_W'(word[3*FIELD_W +: FIELD_W]);
            CLS_TWO:   index = IDX_W'(BASE2) + IDX_W'(word[2*FIELD_W +: FIELD_W]);
            CLS_ONE:   index = IDX_W'(BASE1) + (one_upper ? IDX_W'(SPAN) : '0)
                             + IDX_W'(word[FIELD_W +: FIELD_W]);
            default:   index = IDX_W'(BASE0) + IDX_W'(word[0 +: FIELD_W]);
        endcase
    end

endmodule

// File: rtl/xop_decoder.sv
// Registered decoder for words with a variable-length, escape-extended opcode
module xop_decoder
    import xop_pkg::*;
#(
    parameter int unsigned FIELD_W = 4,
    localparam int unsigned WORD_W = (NOPS + 1) * FIELD_W,
    localparam int unsigned SPAN   = 1 << FIELD_W,
    localparam int unsigned IDX_W  = $clog2(4 * SPAN - 3 + SPAN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_class,
    output logic [IDX_W-1:0]   out_index,
    output logic [FIELD_W-1:0] out_f2,
    output logic [FIELD_W-1:0] out_f1,
    output logic [FIELD_W-1:0] out_f0,
    output logic [NOPS-1:0]    out_used
);
    typedef struct packed {
        logic                        vld;
        opclass_e                    cls;
        logic [IDX_W-1:0]            idx;
        logic [NOPS-1:0][FIELD_W-1:0] fld;
        logic [NOPS-1:0]             used;
    } rec_t;

    opclass_e                     dec_cls;
    logic                         dec_upper;
    logic [IDX_W-1:0]             dec_idx;
    logic [NOPS-1:0][FIELD_W-1:0] dec_fld;
    logic [NOPS-1:0]              dec_used;

    rec_t rec_d, rec_q;
    logic take_d;

    xop_class_detect #(.FIELD_W(FIELD_W)) u_detect (
        .word      (in_word),
        .cls       (dec_cls),
        .one_upper (dec_upper)
    );

    xop_field_extract #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_extract (
        .word      (in_word),
        .cls       (dec_cls),
        .one_upper (dec_upper),
        .index     (dec_idx),
        .fld       (dec_fld),
        .used      (dec_used)
    );

    always_comb begin
        take_d = !rec_q.vld || out_ready;
        rec_d  = rec_q;
        if (take_d) begin
            rec_d.vld = in_valid;
            if (in_valid) begin
                rec_d.cls  = dec_cls;
                rec_d.idx  = dec_idx;
                rec_d.fld  = dec_fld;
                rec_d.used = dec_used;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign in_ready  = take_d;
    assign out_valid = rec_q.vld;
    assign out_class = rec_q.cls;
    assign out_index = rec_q.idx;
    assign out_f2    = rec_q.fld[2];
    assign out_f1    = rec_q.fld[1];
    assign out_f0    = rec_q.fld[0];
    assign out_used  = rec_q.used;

endmodule

// File: rtl/xop_decoder_chk.sv
module xop_decoder_chk #(
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned IDX_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [1:0]         out_class,
    input logic [IDX_W-1:0]   out_index,
    input logic [FIELD_W-1:0] out_f2,
    input logic [FIELD_W-1:0] out_f1,
    input logic [FIELD_W-1:0] out_f0,
    input logic [2:0]         out_used
);
    localparam int unsigned SPAN  = 1 << FIELD_W;
    localparam int unsigned BASE2 = SPAN - 1;
    localparam int unsigned BASE1 = 2 * SPAN - 3;
    localparam int unsigned BASE0 = 4 * SPAN - 4;
    localparam int unsigned LAST  = BASE0 + SPAN - 1;

    // R8: a held record does not change
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid &&
        $stable({out_class, out_index, out_f2, out_f1, out_f0, out_used}));

    // R7: an accepted word yields a valid record on the next cycle
    assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7: a delivered record with no successor leaves the output idle
    assert_idle_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    // R6: fields without their flag read zero
    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_used[2] || out_f2 == '0) &&
                      (out_used[1] || out_f1 == '0) &&
                      (out_used[0] || out_f0 == '0));

    // R6: the flag pattern agrees with the class
    assert_used_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_used == (out_class == 2'b00 ? 3'b111 :
                                   out_class == 2'b01 ? 3'b011 :
                                   out_class == 2'b10 ? 3'b001 : 3'b000));

    // R5: each class keeps to its own slice of the index space
    assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_class == 2'b00 && int'(out_index) <  BASE2) ||
                      (out_class == 2'b01 && int'(out_index) >= BASE2 && int'(out_index) < BASE1) ||
                      (out_class == 2'b10 && int'(out_index) >= BASE1 && int'(out_index) < BASE0) ||
                      (out_class == 2'b11 && int'(out_index) >= BASE0 && int'(out_index) <= LAST));

endmodule

bind xop_decoder xop_decoder_chk #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_class (out_class),
    .out_index (out_index),
    .out_f2    (out_f2),
    .out_f1    (out_f1),
    .out_f0    (out_f0),
    .out_used  (out_used)
);

// File: tb/tb_xop_decoder.sv
`timescale 1ns/1ps
module tb_xop_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_class;
    logic [6:0]  out_index;
    logic [3:0]  out_f2, out_f1, out_f0;
    logic [2:0]  out_used;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xop_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_class(out_class), .out_index(out_index), .out_f2(out_f2),
        .out_f1(out_f1), .out_f0(out_f0), .out_used(out_used)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected decode, written from the requirements
    function automatic void model(input logic [15:0] w, output logic [1:0] c,
                                  output int idx, output logic [2:0] u, output string req);
        if (w[15:12] != 4'hF) begin
            c = 2'b00; idx = int'(w[15:12]); u = 3'b111; req = "R1";
        end else if (w[11:8] <= 4'hD) begin
            c = 2'b01; idx = 15 + int'(w[11:8]); u = 3'b011; req = "R2";
        end else if (w[11:8] == 4'hE) begin
            c = 2'b10; idx = 29 + int'(w[7:4]); u = 3'b001; req = "R3";
        end else if (w[7:4] != 4'hF) begin
            c = 2'b10; idx = 45 + int'(w[7:4]); u = 3'b001; req = "R3";
        end else begin
            c = 2'b11; idx = 60 + int'(w[3:0]); u = 3'b000; req = "R4";
        end
    endfunction

    task automatic check_record(input logic [15:0] w);
        logic [1:0] c; int idx; logic [2:0] u; string req;
        model(w, c, idx, u, req);
        check(out_valid == 1'b1, {req, " valid"}, out_valid, 1);
        check(out_class == c, {req, " class"}, out_class, c);
        check(int'(out_index) == idx, {req, " index"}, out_index, idx);
        check(out_used == u, "R6 used", out_used, u);
        check(out_f2 == (u[2] ? w[11:8] : 4'h0), "R6 f2", out_f2, u[2] ? w[11:8] : 0);
        check(out_f1 == (u[1] ? w[7:4] : 4'h0), "R6 f1", out_f1, u[1] ? w[7:4] : 0);
        check(out_f0 == (u[0] ? w[3:0] : 4'h0), "R6 f0", out_f0, u[0] ? w[3:0] : 0);
    endtask

    // One word through an idle decoder; the result is read one cycle later (R7)
    task automatic t_single(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_record(w);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 drop after delivery", out_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
        check(in_ready == 1'b1, "R7 reset ready", in_ready, 1);
    endtask

    task automatic t_boundaries();
        t_single(16'h0000);  // R1 first
        t_single(16'hEFFF);  // R1 last
        t_single(16'h5A3C);  // R1 mid
        t_single(16'hF000);  // R2 first
        t_single(16'hFD9B);  // R2 last
        t_single(16'hFE00);  // R3 lower first
        t_single(16'hFEF7);  // R3 lower last
        t_single(16'hFF00);  // R3 upper first
        t_single(16'hFFE5);  // R3 upper last
        t_single(16'hFFF0);  // R4 first
        t_single(16'hFFFF);  // R4 last, index 75
    endtask

    // R8: back-pressure holds the record and blocks the input
    task automatic t_stall();
        @(negedge clk);
        in_valid = 1'b1; in_word = 16'h1234; out_ready = 1'b0;
        @(negedge clk);
        in_word = 16'hFFF7;
        for (int k = 0; k < 3; k++) begin
            check(in_ready == 1'b0, "R8 input blocked", in_ready, 0);
            check_record(16'h1234);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_record(16'hFFF7);
        check(int'(out_index) == 67, "R8 waiting word index", out_index, 67);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 idle after stall", out_valid, 0);
    endtask

    // R5: stream every word and tally the classes and indices
    task automatic t_sweep();
        int cnt [4];
        bit seen [128];
        int bad = 0;
        int distinct = 0;
        logic [15:0] prev;
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        for (int k = 0; k < 128; k++) seen[k] = 1'b0;
        out_ready = 1'b1;
        for (int n = 0; n <= 65536; n++) begin
            @(negedge clk);
            if (n > 0) begin
                logic [1:0] c; int idx; logic [2:0] u; string req;
                prev = 16'(n - 1);
                model(prev, c, idx, u, req);
                if (!out_valid || out_class != c || int'(out_index) != idx || out_used != u) begin
                    if (bad == 0)
                        $display("FAIL R5 sweep word %0h: class=%0d index=%0d expected class=%0d index=%0d",
                                 prev, out_class, out_index, c, idx);
                    bad++;
                end
                cnt[out_class]++;
                seen[out_index] = 1'b1;
            end
            if (n < 65536) begin
                in_valid = 1'b1; in_word = 16'(n);
            end else begin
                in_valid = 1'b0;
            end
        end
        checks++;
        if (bad != 0) errors++;
        for (int k = 0; k < 128; k++) if (seen[k]) distinct++;
        check(cnt[0] == 61440, "R5 three-operand count", cnt[0], 61440);
        check(cnt[1] == 3584,  "R5 two-operand count", cnt[1], 3584);
        check(cnt[2] == 496,   "R5 one-operand count", cnt[2], 496);
        check(cnt[3] == 16,    "R5 zero-operand count", cnt[3], 16);
        check(distinct == 76,  "R5 distinct indices", distinct, 76);
        check(seen[75] && !seen[76], "R5 top index 75", seen[76], 0);
        @(negedge clk);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_boundaries();
        t_stall();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule